// File: doc/BRIEF.md
# Interrupt Line Trigger-Mode Selector

This block sits in front of a 16-input interrupt controller core and decides, line by line, how each raw request is detected. Each line can either be caught on its rising edge and held as a pending request until the core acknowledges it, or passed straight through as an active-high level. The selection comes from two byte-wide registers that the host reads and writes with a simple synchronous strobe. Register 0 covers lines 0 to 7, and register 1 covers lines 8 to 15.

Five lines serve system functions and can never be made level-sensitive: 0, 1, 2, 8 and 13. Every raw input passes through a two-stage synchronizer before it is used. Host software can save both registers and write the saved values back later, and the lines then behave exactly as they did before. The detection path of a line switches at run time as soon as its mode bit changes.

Top module: `irq_trigger_ctl`

## Requirements
- R1: Address 0 selects the byte for lines 0-7 and address 1 selects the byte for lines 8-15, with bit k of a byte mapping to line 8*addr+k. A write with `wr_en` high takes effect at the clock edge. `rdata` shows the addressed byte combinationally.
- R2: A mode bit of 1 makes its line level-sensitive and a mode bit of 0 makes it edge-triggered.
- R3: Lines 0, 1, 2, 8 and 13 are always edge-triggered and their bits read as 0 whatever is written. The writable mask is 0xF8 for address 0 and 0xDE for address 1.
- R4: Reading both registers, writing other values and then writing the saved bytes back restores the same readback and the same per-line behaviour.
- R5: In level mode, `irq_req[n]` follows `irq_raw[n]` two clock edges later and is not latched.
- R6: In edge mode, a 0-to-1 change on `irq_raw[n]` sets `irq_req[n]` at the third clock edge after the change. The request then stays high, even after the input falls, until it is cleared.
- R7: A one-cycle `irq_clr[n]` pulse drops an edge-mode request at the next clock edge. If a new rising edge is detected in that same cycle, the request stays set.
- R8: While a line is in level mode its edge latch is kept empty. When the line switches back to edge mode it has no pending request, and an input that is already high does not create one.
- R9: Reset clears both registers, so every line starts in edge mode, and drives all requests low.
- R10: `irq_clr` has no effect on a line in level mode, whose output keeps following the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select (0: lines 0-7, 1: lines 8-15) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| irq_raw | input | 16 | Raw asynchronous request lines |
| irq_clr | input | 16 | Per-line acknowledge that clears a latched edge request |
| irq_req | output | 16 | Conditioned requests to the controller core |

## Verification
Directed patterns come first. A single rising pulse that falls again separates edge latching from level pass-through, and sampling it cycle by cycle pins the two-edge and three-edge latencies. Holding an input high across a mode switch shows whether the switch creates a false edge. A clear that arrives together with a fresh edge shows which of the two wins. Writing all ones to both registers shows that the reserved lines stay edge-triggered. Random mixes of register writes, raw patterns and clear vectors then check many lines at once in mixed modes against a reference model kept in the bench.

// File: rtl/trig_pkg.sv
package trig_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [1:0] sync;
        logic       prev;
        logic       req;
    } line_state_t;
endpackage

// File: rtl/trig_regs.sv
module trig_regs #(
    parameter int                 NUM_LINES     = 16,
    parameter int                 ADDR_W        = 1,
    parameter logic [NUM_LINES-1:0] RESERVED_MASK = 16'h2107
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [trig_pkg::BYTE_W-1:0] wdata,
    output logic [trig_pkg::BYTE_W-1:0] rdata,
    output logic [NUM_LINES-1:0]   mode_o
);
    import trig_pkg::*;
    localparam int NUM_REGS = NUM_LINES / BYTE_W;

    logic [NUM_LINES-1:0] mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (wr_en && (int'(addr) < NUM_REGS))
            mode_d[int'(addr)*BYTE_W +: BYTE_W] = wdata;
        mode_d = mode_d & ~RESERVED_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    assign rdata  = mode_q[int'(addr)*BYTE_W +: BYTE_W];
    assign mode_o = mode_q;

    // R3: reserved positions never read back as 1
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & RESERVED_MASK[int'(addr)*BYTE_W +: BYTE_W]) == '0);

    // R1: a write to the low byte is visible on the next cycle
    a_r1_write_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0) |=>
        mode_o[BYTE_W-1:0] == ($past(wdata) & ~RESERVED_MASK[BYTE_W-1:0]));
endmodule

// File: rtl/trig_line.sv
module trig_line (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic lvl_i,
    input  logic clr_i,
    output logic req_o
);
    import trig_pkg::*;

    line_state_t st_d, st_q;
    logic        rise;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], raw_i};
        st_d.prev = st_q.sync[1];
        rise      = st_q.sync[1] & ~st_q.prev;
        if (lvl_i) st_d.req = 1'b0;
        else       st_d.req = (st_q.req & ~clr_i) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = lvl_i ? st_q.sync[1] : st_q.req;

    // R6: a latched edge request is held until a clear or a mode change
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.req && !clr_i && !lvl_i) |=> st_q.req);

    // R7: a clear without a new edge drops the request
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.req && clr_i && !lvl_i && !(st_q.sync[1] && !st_q.prev)) |=> !st_q.req);

    // R8: the latch stays empty while the line is in level mode
    a_r8_level_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_i && $past(lvl_i)) |-> !st_q.req);

    // R6: a request only appears after the synchronized input was seen rising
    a_r6_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.req) |-> $past(st_q.sync[1]));
endmodule

// File: rtl/irq_trigger_ctl.sv
module irq_trigger_ctl #(
    parameter int                   NUM_LINES     = 16,
    parameter logic [NUM_LINES-1:0] RESERVED_MASK = 16'h2107
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 addr,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata,
    input  logic [NUM_LINES-1:0] irq_raw,
    input  logic [NUM_LINES-1:0] irq_clr,
    output logic [NUM_LINES-1:0] irq_req
);
    logic [NUM_LINES-1:0] mode;

    trig_regs #(
        .NUM_LINES     (NUM_LINES),
        .ADDR_W        (1),
        .RESERVED_MASK (RESERVED_MASK)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .mode_o (mode)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        trig_line u_line (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (irq_raw[i]),
            .lvl_i (mode[i]),
            .clr_i (irq_clr[i]),
            .req_o (irq_req[i])
        );
    end

    // R9: requests are low in the first cycle after reset
    a_r9_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> irq_req == '0);
endmodule

// File: tb/tb_irq_trigger_ctl.sv
module tb_irq_trigger_ctl;
    localparam logic [15:0] WMASK = 16'hDEF8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        addr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] irq_raw = '0;
    logic [15:0] irq_clr = '0;
    logic [15:0] irq_req;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] exp_mode = '0;
    logic [15:0] exp_edge = '0;
    logic [15:0] raw_cur  = '0;

    always #5 clk = ~clk;

    irq_trigger_ctl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_raw(irq_raw), .irq_clr(irq_clr), .irq_req(irq_req)
    );

    function automatic logic [15:0] exp_req();
        return (exp_mode & raw_cur) | (~exp_mode & exp_edge);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a) exp_mode[15:8] = d & WMASK[15:8];
        else   exp_mode[7:0]  = d & WMASK[7:0];
        exp_edge &= ~exp_mode;
    endtask

    task automatic rd_chk(input string tag, input logic a);
        addr = a;
        #1;
        chk(tag, {8'h0, rdata}, {8'h0, a ? exp_mode[15:8] : exp_mode[7:0]});
    endtask

    task automatic set_raw(input logic [15:0] v);
        exp_edge |= v & ~raw_cur & ~exp_mode;
        raw_cur  = v;
        irq_raw  = v;
        step(4);
    endtask

    task automatic pulse_clr(input logic [15:0] c);
        irq_clr = c;
        step(1);
        irq_clr = '0;
        exp_edge &= ~c;
        step(1);
    endtask

    initial begin
        #1_000_000;
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] sv_lo, sv_hi;
        void'($urandom(32'd2024));
        step(2);
        chk("R9 req after reset", irq_req, 16'h0);
        rd_chk("R9 reg0 reset", 1'b0);
        rd_chk("R9 reg1 reset", 1'b1);
        rst_n = 1'b1;
        step(1);

        // R1/R3: write all ones, reserved bits read zero
        wr(1'b0, 8'hFF); wr(1'b1, 8'hFF);
        rd_chk("R3 reg0 mask", 1'b0);
        chk("R3 reg0 value", {8'h0, rdata}, 16'h00F8);
        rd_chk("R3 reg1 mask", 1'b1);
        chk("R3 reg1 value", {8'h0, rdata}, 16'h00DE);

        // R5 latency on line 3 (level)
        irq_raw[3] = 1'b1; raw_cur[3] = 1'b1;
        step(1); chk("R5 level not yet", {15'h0, irq_req[3]}, 16'h0);
        step(1); chk("R5 level after 2", {15'h0, irq_req[3]}, 16'h1);
        // R10: clear has no effect on level line
        pulse_clr(16'h0008);
        chk("R10 clr ignored in level", {15'h0, irq_req[3]}, 16'h1);
        irq_raw[3] = 1'b0; raw_cur[3] = 1'b0;
        step(2); chk("R5 level follows low", {15'h0, irq_req[3]}, 16'h0);

        // R3: reserved line 0 stays edge even though written 1
        irq_raw[0] = 1'b1; raw_cur[0] = 1'b1;
        step(2); chk("R3 line0 not yet", {15'h0, irq_req[0]}, 16'h0);
        step(1); chk("R6 line0 edge after 3", {15'h0, irq_req[0]}, 16'h1);
        irq_raw[0] = 1'b0; raw_cur[0] = 1'b0;
        step(4); chk("R6 line0 sticky", {15'h0, irq_req[0]}, 16'h1);
        exp_edge[0] = 1'b1;
        pulse_clr(16'h0001);
        chk("R7 line0 cleared", {15'h0, irq_req[0]}, 16'h0);

        // R8: line 4 high in level mode, switch to edge, no request
        set_raw(16'h0010);
        chk("R2 line4 level high", irq_req, exp_req());
        wr(1'b0, 8'h00);
        step(4);
        chk("R8 switch no request", {15'h0, irq_req[4]}, 16'h0);
        set_raw(16'h0000);

        // R7: clear coincides with newly detected edge on line 5
        irq_raw[5] = 1'b1; raw_cur[5] = 1'b1;
        step(2);   // sync[1] high, rise visible during next cycle
        irq_clr[5] = 1'b1;
        step(1);
        irq_clr[5] = 1'b0;
        step(1);
        chk("R7 edge wins over clear", {15'h0, irq_req[5]}, 16'h1);
        exp_edge[5] = 1'b1;
        pulse_clr(16'h0020);
        chk("R7 cleared later", {15'h0, irq_req[5]}, 16'h0);

        // R4: save, scramble, restore
        wr(1'b0, 8'hA8); wr(1'b1, 8'h56);
        addr = 1'b0; #1; sv_lo = rdata;
        addr = 1'b1; #1; sv_hi = rdata;
        wr(1'b0, 8'h00); wr(1'b1, 8'hFF);
        wr(1'b0, sv_lo); wr(1'b1, sv_hi);
        rd_chk("R4 restore reg0", 1'b0);
        rd_chk("R4 restore reg1", 1'b1);
        set_raw(16'hFFFF);
        chk("R4 behaviour after restore", irq_req, exp_req());
        set_raw(16'h0000);
        chk("R4 edge vs level split", irq_req, exp_req());
        pulse_clr(16'hFFFF);

        // Random mix
        for (int it = 0; it < 80; it++) begin
            int op;
            op = $urandom_range(0, 3);
            case (op)
                0: wr(1'($urandom_range(0, 1)), 8'($urandom));
                1: begin set_raw(16'($urandom)); chk("R6 random raw", irq_req, exp_req()); end
                2: begin pulse_clr(16'($urandom)); chk("R7 random clear", irq_req, exp_req()); end
                default: begin
                    rd_chk("R1 random read", 1'($urandom_range(0, 1)));
                    step(1);
                end
            endcase
        end
        step(4);
        chk("R2 final outputs", irq_req, exp_req());

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule